// File: doc/BRIEF.md
# Four-Channel Configurable Pin Controller

This block drives four general-purpose pins from a small byte-wide register interface. Each pin has four working settings: an output level, a direction, a drive type (push-pull or open-drain) and a read-inversion bit. Two further bytes model nonvolatile storage that holds the power-on defaults for those settings. A power-on event loads both the stored bytes and the working settings with factory values. The block reset copies whatever the stored bytes currently hold into the working settings. After reset a host can rewrite the working settings freely without touching the stored defaults.

Each pin is presented as an output value plus an output-enable, which lets the surrounding pad model tri-state and open-drain drive. The external pin levels pass through a two-stage synchroniser. An access register returns, for every pin, either its synchronised level or its own output latch, XOR its inversion bit. The serial front end that produces the register accesses lies outside this block, and so does the physical write cycle of the nonvolatile storage.

Register map, all 8 bits wide. A nibble field's bit i belongs to pin i. 20h holds the stored defaults {direction, output level}. 21h holds the stored defaults {drive type, inversion}. 28h holds the working {direction, output level}. 29h holds the working {drive type, inversion}. 2Ch is the access register: a read returns {output latches, pin read values}, and a write sets the output latches from its lower nibble. For direction, 1 means input and 0 means output. For drive type, 1 means open-drain and 0 means push-pull.

Top module: `qpc_top`

## Requirements
- R1: On power-on (pwr_on_n low) both stored bytes take the factory values 1Fh (20h) and F0h (21h), and the working settings take the same values. After release, 28h reads 1Fh and 29h reads F0h. Every pin then has pin_oe = 0 and pin_o = 0, because pin 0 is an input and pins 1-3 are open-drain outputs that are released high. With all pins low, 2Ch reads FEh.
- R2: While rst_n is low, each clock copies 20h into 28h and 21h into 29h. The stored bytes keep their contents across this reset.
- R3: A write to 28h or 29h changes the working settings and the pin drive from the next clock edge, and leaves 20h and 21h unchanged.
- R4: A write to 20h or 21h changes the stored byte, which reads back at once, but the working settings keep their values until the next rst_n pulse.
- R5: A pin whose direction bit is 1 has pin_oe = 0 and pin_o = 0.
- R6: For an output pin, push-pull drive gives pin_oe = 1 and pin_o = its output level. Open-drain drive gives pin_o = 0 always, with pin_oe = 1 for a low level and pin_oe = 0 for a high level.
- R7: For an output pin, bit i of the lower nibble of 2Ch reads its output level XOR its inversion bit.
- R8: For an input pin, bit i of the lower nibble of 2Ch reads the external level XOR its inversion bit. A level applied between two clock edges shows up after the second following edge and not after the first.
- R9: A write to 2Ch sets the output levels from its lower nibble and ignores its upper nibble, so direction is unchanged. The upper nibble of a 2Ch read returns the output levels.
- R10: An address outside the map reads FFh, and a write to it changes no register.
- R11: Writes issued while rst_n is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_n | input | 1 | Power-on event, active low, asynchronous; loads factory values |
| rst_n | input | 1 | Block reset, active low, sampled on clk; reloads working settings from stored bytes |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_i | input | 4 | External pin levels |
| pin_o | output | 4 | Pin output values |
| pin_oe | output | 4 | Pin output enables |

## Verification
The direction change of a pin and the sampling of its external level can coincide. The synchroniser samples on every clock regardless of direction, so in the clock where a write turns an output into an input, the read value must switch from the output latch straight to the settled external level, with no two-cycle gap. The bench provokes this by holding pin 0 high externally while it drives low, then writing direction 1. It judges the access register at the very next half cycle. A second coincidence is a reset reload that falls together with a stored-byte write. The bench issues writes while rst_n is low and checks that the reload reflects the old stored byte and that the write has been discarded.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  localparam logic [7:0] A_DFLT_LVL = 8'h20;
  localparam logic [7:0] A_DFLT_TYP = 8'h21;
  localparam logic [7:0] A_WORK_LVL = 8'h28;
  localparam logic [7:0] A_WORK_TYP = 8'h29;
  localparam logic [7:0] A_ACCESS   = 8'h2C;

  typedef enum logic [2:0] {
    SEL_DLVL, SEL_DTYP, SEL_WLVL, SEL_WTYP, SEL_ACC, SEL_NONE
  } qpc_sel_e;

  function automatic qpc_sel_e f_decode(input logic [7:0] a);
    case (a)
      A_DFLT_LVL: f_decode = SEL_DLVL;
      A_DFLT_TYP: f_decode = SEL_DTYP;
      A_WORK_LVL: f_decode = SEL_WLVL;
      A_WORK_TYP: f_decode = SEL_WTYP;
      A_ACCESS:   f_decode = SEL_ACC;
      default:    f_decode = SEL_NONE;
    endcase
  endfunction

  // output enable of one pin: inputs float, open-drain releases a high
  function automatic logic f_pin_oe(input logic is_in, input logic is_od,
                                    input logic lvl);
    if (is_in)      f_pin_oe = 1'b0;
    else if (is_od) f_pin_oe = ~lvl;
    else            f_pin_oe = 1'b1;
  endfunction

  // driven value of one pin: only push-pull outputs drive a level
  function automatic logic f_pin_o(input logic is_in, input logic is_od,
                                   input logic lvl);
    f_pin_o = (!is_in && !is_od) ? lvl : 1'b0;
  endfunction

  // value seen by a read of the access register
  function automatic logic f_pin_rd(input logic is_in, input logic lvl,
                                    input logic inv, input logic ext);
    f_pin_rd = (is_in ? ext : lvl) ^ inv;
  endfunction
endpackage

// File: rtl/qpc_regs.sv
module qpc_regs import qpc_pkg::*; #(
  parameter int NPIN = 4,
  parameter logic [2*NPIN-1:0] FACT_LVL = 8'h1F,
  parameter logic [2*NPIN-1:0] FACT_TYP = 8'hF0
) (
  input  logic            clk,
  input  logic            pwr_on_n,
  input  logic            rst_n,
  input  logic            we,
  input  qpc_sel_e        sel,
  input  logic [2*NPIN-1:0] wdata,
  output logic [2*NPIN-1:0] nv_lvl,
  output logic [2*NPIN-1:0] nv_typ,
  output logic [NPIN-1:0] lvl_q,
  output logic [NPIN-1:0] dir_q,
  output logic [NPIN-1:0] inv_q,
  output logic [NPIN-1:0] od_q
);
  localparam int DW = 2 * NPIN;

  logic wr_ok;
  logic wr_dlvl, wr_dtyp, wr_wlvl, wr_wtyp, wr_acc;

  assign wr_ok   = we && rst_n;
  assign wr_dlvl = wr_ok && (sel == SEL_DLVL);
  assign wr_dtyp = wr_ok && (sel == SEL_DTYP);
  assign wr_wlvl = wr_ok && (sel == SEL_WLVL);
  assign wr_wtyp = wr_ok && (sel == SEL_WTYP);
  assign wr_acc  = wr_ok && (sel == SEL_ACC);

  // stored default bytes: only the power-on event restores factory values
  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      nv_lvl <= FACT_LVL;
      nv_typ <= FACT_TYP;
    end else begin
      if (wr_dlvl) nv_lvl <= wdata;
      if (wr_dtyp) nv_typ <= wdata;
    end
  end

  // working settings: factory on power-on, stored bytes during reset
  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      {dir_q, lvl_q} <= FACT_LVL;
      {od_q, inv_q}  <= FACT_TYP;
    end else if (!rst_n) begin
      {dir_q, lvl_q} <= nv_lvl;
      {od_q, inv_q}  <= nv_typ;
    end else begin
      if (wr_wlvl) {dir_q, lvl_q} <= wdata;
      if (wr_wtyp) {od_q, inv_q}  <= wdata;
      if (wr_acc)  lvl_q          <= wdata[NPIN-1:0];
    end
  end

  logic [DW-1:0] unused_chk;
  assign unused_chk = '0;
endmodule

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int NPIN   = 4,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            pwr_on_n,
  input  logic [NPIN-1:0] d,
  output logic [NPIN-1:0] q
);
  logic [NPIN-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge pwr_on_n) begin
        if (!pwr_on_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qpc_pad.sv
module qpc_pad import qpc_pkg::*; #(
  parameter int NPIN = 4
) (
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] od_q,
  input  logic [NPIN-1:0] lvl_q,
  input  logic [NPIN-1:0] inv_q,
  input  logic [NPIN-1:0] ext_s,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] rd_val
);
  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      assign pin_oe[i] = f_pin_oe(dir_q[i], od_q[i], lvl_q[i]);
      assign pin_o[i]  = f_pin_o(dir_q[i], od_q[i], lvl_q[i]);
      assign rd_val[i] = f_pin_rd(dir_q[i], lvl_q[i], inv_q[i], ext_s[i]);
    end
  endgenerate
endmodule

// File: rtl/qpc_top.sv
module qpc_top import qpc_pkg::*; #(
  parameter int NPIN = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [2*NPIN-1:0] FACT_LVL = 8'h1F,
  parameter logic [2*NPIN-1:0] FACT_TYP = 8'hF0
) (
  input  logic            clk,
  input  logic            pwr_on_n,
  input  logic            rst_n,
  input  logic [7:0]      bus_addr,
  input  logic [2*NPIN-1:0] bus_wdata,
  input  logic            bus_we,
  output logic [2*NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_o,
  output logic [NPIN-1:0] pin_oe
);
  localparam int DW = 2 * NPIN;

  qpc_sel_e        sel;
  logic [DW-1:0]   nv_lvl, nv_typ;
  logic [NPIN-1:0] lvl_q, dir_q, inv_q, od_q;
  logic [NPIN-1:0] ext_s, rd_val;

  assign sel = f_decode(bus_addr);

  qpc_regs #(.NPIN(NPIN), .FACT_LVL(FACT_LVL), .FACT_TYP(FACT_TYP)) u_regs (
    .clk(clk), .pwr_on_n(pwr_on_n), .rst_n(rst_n), .we(bus_we), .sel(sel),
    .wdata(bus_wdata), .nv_lvl(nv_lvl), .nv_typ(nv_typ),
    .lvl_q(lvl_q), .dir_q(dir_q), .inv_q(inv_q), .od_q(od_q)
  );

  qpc_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .pwr_on_n(pwr_on_n), .d(pin_i), .q(ext_s)
  );

  qpc_pad #(.NPIN(NPIN)) u_pad (
    .dir_q(dir_q), .od_q(od_q), .lvl_q(lvl_q), .inv_q(inv_q),
    .ext_s(ext_s), .pin_o(pin_o), .pin_oe(pin_oe), .rd_val(rd_val)
  );

  always_comb begin
    case (sel)
      SEL_DLVL: bus_rdata = nv_lvl;
      SEL_DTYP: bus_rdata = nv_typ;
      SEL_WLVL: bus_rdata = {dir_q, lvl_q};
      SEL_WTYP: bus_rdata = {od_q, inv_q};
      SEL_ACC:  bus_rdata = {lvl_q, rd_val};
      default:  bus_rdata = '1;
    endcase
  end
endmodule

// File: rtl/qpc_chk.sv
module qpc_chk import qpc_pkg::*; #(
  parameter int NPIN = 4
) (
  input logic            clk,
  input logic            pwr_on_n,
  input logic            rst_n,
  input logic            bus_we,
  input logic [7:0]      bus_addr,
  input logic [2*NPIN-1:0] bus_wdata,
  input logic [2*NPIN-1:0] bus_rdata,
  input logic [2*NPIN-1:0] nv_lvl,
  input logic [2*NPIN-1:0] nv_typ,
  input logic [NPIN-1:0] lvl_q,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] inv_q,
  input logic [NPIN-1:0] od_q,
  input logic [NPIN-1:0] pin_o,
  input logic [NPIN-1:0] pin_oe
);
  // R2: reset cycle copies the stored bytes into the working settings
  a_r2_reload: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !rst_n |=> ({dir_q, lvl_q} == $past(nv_lvl)) && ({od_q, inv_q} == $past(nv_typ)));

  // R3: a working write lands next edge, stored bytes untouched
  a_r3_work_write: assert property (@(posedge clk) disable iff (!pwr_on_n || !rst_n)
    (bus_we && bus_addr == A_WORK_LVL) |=>
      ({dir_q, lvl_q} == $past(bus_wdata)) && $stable(nv_lvl) && $stable(nv_typ));

  // R10: writes outside the map change nothing
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!pwr_on_n || !rst_n)
    (bus_we && f_decode(bus_addr) == SEL_NONE) |=>
      $stable(nv_lvl) && $stable(nv_typ) && $stable({dir_q, lvl_q}) && $stable({od_q, inv_q}));

  // R11: stored bytes ignore writes during reset
  a_r11_reset_wr: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !rst_n |=> $stable(nv_lvl) && $stable(nv_typ));

  generate
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
      // R5: inputs never drive
      a_r5_input_float: assert property (@(posedge clk) disable iff (!pwr_on_n)
        dir_q[i] |-> !pin_oe[i] && !pin_o[i]);
      // R6: open-drain never drives a one
      a_r6_od_low_only: assert property (@(posedge clk) disable iff (!pwr_on_n)
        od_q[i] |-> !pin_o[i]);
      // R7: output read-back at the bus
      a_r7_out_readback: assert property (@(posedge clk) disable iff (!pwr_on_n)
        (bus_addr == A_ACCESS && !dir_q[i]) |-> bus_rdata[i] == (lvl_q[i] ^ inv_q[i]));
    end
  endgenerate
endmodule

bind qpc_top qpc_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .pwr_on_n(pwr_on_n), .rst_n(rst_n), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .nv_lvl(nv_lvl), .nv_typ(nv_typ), .lvl_q(lvl_q), .dir_q(dir_q),
  .inv_q(inv_q), .od_q(od_q), .pin_o(pin_o), .pin_oe(pin_oe)
);

// File: tb/qpc_top_tb.sv
module qpc_top_tb;
  logic       clk = 1'b0;
  logic       pwr_on_n = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [3:0] pin_i = 4'h0;
  logic [3:0] pin_o, pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  qpc_top u_dut (
    .clk(clk), .pwr_on_n(pwr_on_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  // {lvl byte, type byte, pins, exp oe, exp o, exp read nibble}
  localparam logic [31:0] VEC [6] = '{
    {8'h0F, 8'h00, 4'h0, 4'hF, 4'hF, 4'hF},
    {8'h05, 8'hF0, 4'h0, 4'hA, 4'h0, 4'h5},
    {8'hF0, 8'h00, 4'h9, 4'h0, 4'h0, 4'h9},
    {8'hF0, 8'h0F, 4'h9, 4'h0, 4'h0, 4'h6},
    {8'hC3, 8'h5A, 4'hE, 4'h2, 4'h2, 4'h5},
    {8'h3C, 8'hA5, 4'h1, 4'h4, 4'h4, 4'h8}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    bus_we = 1'b0;
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    pwr_on_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", {4'h0, pin_oe}, 8'h00);
    chk("R1 pin_o", {4'h0, pin_o}, 8'h00);
    rd(8'h28, v); chk("R1 work lvl", v, 8'h1F);
    rd(8'h29, v); chk("R1 work typ", v, 8'hF0);
    rd(8'h20, v); chk("R1 stored lvl", v, 8'h1F);
    rd(8'h2C, v); chk("R1 access", v, 8'hFE);

    // table: R3 R5 R6 R7 R8
    for (int k = 0; k < 6; k++) begin
      pin_i = VEC[k][15:12];
      wr(8'h28, VEC[k][31:24]);
      wr(8'h29, VEC[k][23:16]);
      repeat (2) @(negedge clk);
      chk("R5/R6 oe", {4'h0, pin_oe}, {4'h0, VEC[k][11:8]});
      chk("R6 o", {4'h0, pin_o}, {4'h0, VEC[k][7:4]});
      rd(8'h2C, v);
      chk("R7/R8 read", {4'h0, v[3:0]}, {4'h0, VEC[k][3:0]});
    end
    rd(8'h20, v); chk("R3 stored lvl kept", v, 8'h1F);
    rd(8'h21, v); chk("R3 stored typ kept", v, 8'hF0);

    // R8 synchroniser latency
    pin_i = 4'h0;
    wr(8'h28, 8'hF0);
    wr(8'h29, 8'h00);
    repeat (3) @(negedge clk);
    pin_i = 4'hF;
    @(negedge clk);
    rd(8'h2C, v); chk("R8 after one edge", {4'h0, v[3:0]}, 8'h00);
    @(negedge clk);
    rd(8'h2C, v); chk("R8 after two edges", {4'h0, v[3:0]}, 8'h0F);

    // R9 access write ignores upper nibble
    wr(8'h28, 8'h30);
    wr(8'h2C, 8'hA5);
    rd(8'h28, v); chk("R9 dir kept lvl set", v, 8'h35);
    rd(8'h2C, v); chk("R9 upper nibble levels", {v[7:4], 4'h0}, 8'h50);

    // direction flip meets a settled external level (coincidence case)
    pin_i = 4'h1;
    wr(8'h29, 8'h00);
    wr(8'h28, 8'h00);
    repeat (2) @(negedge clk);
    rd(8'h2C, v); chk("R7 pin0 driven low", {7'h0, v[0]}, 8'h00);
    wr(8'h28, 8'h10);
    rd(8'h2C, v); chk("R8 pin0 reads ext at once", {7'h0, v[0]}, 8'h01);

    // R10 unmapped address
    wr(8'h77, 8'h00);
    rd(8'h77, v); chk("R10 unmapped reads FF", v, 8'hFF);
    rd(8'h28, v); chk("R10 work lvl kept", v, 8'h10);
    rd(8'h20, v); chk("R10 stored lvl kept", v, 8'h1F);

    // R4 stored byte write, working unchanged until reset
    wr(8'h20, 8'h30);
    wr(8'h21, 8'h0F);
    rd(8'h20, v); chk("R4 stored lvl reads new", v, 8'h30);
    rd(8'h28, v); chk("R4 work lvl kept", v, 8'h10);
    rd(8'h29, v); chk("R4 work typ kept", v, 8'h00);

    // R2 + R11 reset reload with writes during reset
    @(negedge clk); rst_n = 1'b0;
    wr(8'h20, 8'h55);
    wr(8'h28, 8'hAA);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(8'h28, v); chk("R2 work lvl reloaded", v, 8'h30);
    rd(8'h29, v); chk("R2 work typ reloaded", v, 8'h0F);
    rd(8'h20, v); chk("R11 stored write ignored", v, 8'h30);

    summary();
  end
endmodule